// File: doc/BRIEF.md
# Streaming Multiply-Command Scanner

The block reads a stream of ASCII bytes, one per cycle in which `in_valid_i` is high, and looks for multiply commands written as `mul(A,B)`. A and B are each one to three decimal digits. For every well-formed command it turns both operands into binary, multiplies them and adds the product to a running sum. It also follows two switch commands, `do()` and `don't()`. These turn the adding of later products on and off.

The recent characters are held in a short shift register. When a closing parenthesis arrives, every legal pair of operand lengths is tested against that history at the same time. The decoded operands are registered, and the multiply-add happens on the next edge. A one-beat end strobe marks the end of the input. The sum is final when `done_o` rises.

Top module: `mul_cmd_scanner`

## Requirements
- R1: When a valid `)` (0x29) arrives and the characters before it read `mul(` (0x6D 0x75 0x6C 0x28), then 1 to 3 digits (0x30 to 0x39), then `,` (0x2C), then 1 to 3 digits, the command is accepted. All nine length pairs are recognised.
- R2: Each operand is read as decimal with its most significant digit first. The product A*B is added to `sum_o`, modulo 2^ACC_W.
- R3: A command is ignored if any of the following holds: a non-digit inside an operand, an empty operand, an operand of more than 3 digits, a missing comma, or a broken `mul(` prefix.
- R4: `sum_o` changes only because of an accepted command. The new value shows one cycle after the edge that samples its `)`.
- R5: Reset (`rst_ni` low, asynchronous) sets `sum_o` to 0 and `done_o` to 0, and turns adding on.
- R6: `don't()` turns adding off for commands that close later. `do()` turns it back on. A command that closes while adding is off adds nothing.
- R7: When `in_valid_i` is low, `in_char_i` is ignored. It neither enters the history nor completes a command.
- R8: `done_o` rises on the clock edge after the one that samples `end_i` high, and stays high until reset. At that point `sum_o` includes every command closed at or before the `end_i` beat, including a `)` given in the same beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | `in_char_i` holds a character this cycle |
| in_char_i | input | 8 | ASCII character |
| end_i | input | 1 | End-of-input strobe, one cycle |
| sum_o | output | ACC_W | Running sum of enabled products |
| done_o | output | 1 | Sum is final |

## Verification
The closing `)` of the last command and the end strobe can land on the same beat. In that case the pending product must still reach `sum_o` by the time `done_o` rises. The bench raises `end_i` together with the last character in most runs, and a few cycles later in the others. One cycle after that beat it checks that `sum_o` still lacks the last product and `done_o` is low. One cycle later it checks that both are final against a reference parser written in the bench.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam logic [7:0] CH_M     = 8'h6D;
  localparam logic [7:0] CH_U     = 8'h75;
  localparam logic [7:0] CH_L     = 8'h6C;
  localparam logic [7:0] CH_LP    = 8'h28;
  localparam logic [7:0] CH_RP    = 8'h29;
  localparam logic [7:0] CH_COMMA = 8'h2C;
  localparam logic [7:0] CH_D     = 8'h64;
  localparam logic [7:0] CH_O     = 8'h6F;
  localparam logic [7:0] CH_N     = 8'h6E;
  localparam logic [7:0] CH_APOS  = 8'h27;
  localparam logic [7:0] CH_T     = 8'h74;

  function automatic logic is_digit(logic [7:0] c);
    return (c >= 8'h30) && (c <= 8'h39);
  endfunction
endpackage

// File: rtl/mcs_window.sv
module mcs_window #(
  parameter int unsigned WIN_LEN = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [7:0]               char_i,
  output logic [WIN_LEN-1:0][7:0]  win_o
);
  logic [WIN_LEN-2:0][7:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (valid_i) hist_q <= {hist_q[WIN_LEN-3:0], char_i};
  end

  // index 0 is the arriving character, higher index is older
  assign win_o = {hist_q, char_i};
endmodule

// File: rtl/mcs_match.sv
module mcs_match
  import mcs_pkg::*;
#(
  parameter int unsigned DIGITS  = 3,
  parameter int unsigned WIN_LEN = 2 * DIGITS + 6,
  parameter int unsigned OP_W    = 10
) (
  input  logic [WIN_LEN-1:0][7:0] win_i,
  output logic                    mul_hit_o,
  output logic [OP_W-1:0]         op_a_o,
  output logic [OP_W-1:0]         op_b_o,
  output logic                    do_hit_o,
  output logic                    dont_hit_o
);
  localparam int unsigned NCOMB = DIGITS * DIGITS;

  logic [NCOMB-1:0] hit;
  logic [OP_W-1:0]  va [NCOMB];
  logic [OP_W-1:0]  vb [NCOMB];

  for (genvar la = 1; la <= DIGITS; la++) begin : g_a
    for (genvar lb = 1; lb <= DIGITS; lb++) begin : g_b
      localparam int unsigned IDX = (la - 1) * DIGITS + (lb - 1);
      localparam int unsigned CI  = lb + 1;      // comma
      localparam int unsigned AI  = lb + 2;      // lowest digit of A
      localparam int unsigned PI  = lb + la + 2; // open paren
      logic            ok;
      logic [OP_W-1:0] a_v, b_v;

      always_comb begin
        ok = (win_i[0] == CH_RP) && (win_i[CI] == CH_COMMA) &&
             (win_i[PI] == CH_LP) && (win_i[PI+1] == CH_L) &&
             (win_i[PI+2] == CH_U) && (win_i[PI+3] == CH_M);
        b_v = '0;
        for (int k = lb; k >= 1; k--) begin
          ok  = ok && is_digit(win_i[k]);
          b_v = OP_W'(b_v * 10 + win_i[k][3:0]);
        end
        a_v = '0;
        for (int k = la - 1; k >= 0; k--) begin
          ok  = ok && is_digit(win_i[AI+k]);
          a_v = OP_W'(a_v * 10 + win_i[AI+k][3:0]);
        end
      end

      assign hit[IDX] = ok;
      assign va[IDX]  = a_v;
      assign vb[IDX]  = b_v;
    end
  end

  // length pairs are mutually exclusive, so OR-select is safe
  always_comb begin
    op_a_o = '0;
    op_b_o = '0;
    for (int i = 0; i < NCOMB; i++) begin
      if (hit[i]) begin
        op_a_o = op_a_o | va[i];
        op_b_o = op_b_o | vb[i];
      end
    end
  end

  assign mul_hit_o  = |hit;
  assign do_hit_o   = (win_i[0] == CH_RP) && (win_i[1] == CH_LP) &&
                      (win_i[2] == CH_O)  && (win_i[3] == CH_D);
  assign dont_hit_o = (win_i[0] == CH_RP) && (win_i[1] == CH_LP) &&
                      (win_i[2] == CH_T)  && (win_i[3] == CH_APOS) &&
                      (win_i[4] == CH_N)  && (win_i[5] == CH_O) &&
                      (win_i[6] == CH_D);
endmodule

// File: rtl/mcs_accum.sv
module mcs_accum #(
  parameter int unsigned OP_W  = 10,
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             mul_hit_i,
  input  logic             do_hit_i,
  input  logic             dont_hit_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic             end_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             done_o,
  output logic             en_o
);
  logic              en_q, pend_q, end_q, done_q;
  logic [OP_W-1:0]   a_q, b_q;
  logic [ACC_W-1:0]  acc_q;
  logic [2*OP_W-1:0] prod;

  assign prod = a_q * b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b1;
      pend_q <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      end_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (valid_i && dont_hit_i)    en_q <= 1'b0;
      else if (valid_i && do_hit_i) en_q <= 1'b1;
      pend_q <= valid_i && mul_hit_i && en_q;
      if (valid_i && mul_hit_i) begin
        a_q <= op_a_i;
        b_q <= op_b_i;
      end
      if (pend_q) acc_q <= acc_q + ACC_W'(prod);
      // end_q delay lines up done with the last pending add
      end_q <= end_i;
      if (end_q) done_q <= 1'b1;
    end
  end

  assign sum_o  = acc_q;
  assign done_o = done_q;
  assign en_o   = en_q;
endmodule

// File: rtl/mul_cmd_scanner.sv
module mul_cmd_scanner #(
  parameter int unsigned OP_DIGITS = 3,
  parameter int unsigned ACC_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_char_i,
  input  logic             end_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             done_o
);
  localparam int unsigned WIN_LEN = 2 * OP_DIGITS + 6;
  localparam int unsigned OP_W    = $clog2(10 ** OP_DIGITS);

  logic [WIN_LEN-1:0][7:0] win_w;
  logic                    mul_hit_w, do_hit_w, dont_hit_w, en_w;
  logic [OP_W-1:0]         op_a_w, op_b_w;

  mcs_window #(.WIN_LEN(WIN_LEN)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .char_i  (in_char_i),
    .win_o   (win_w)
  );

  mcs_match #(.DIGITS(OP_DIGITS), .WIN_LEN(WIN_LEN), .OP_W(OP_W)) u_match (
    .win_i      (win_w),
    .mul_hit_o  (mul_hit_w),
    .op_a_o     (op_a_w),
    .op_b_o     (op_b_w),
    .do_hit_o   (do_hit_w),
    .dont_hit_o (dont_hit_w)
  );

  mcs_accum #(.OP_W(OP_W), .ACC_W(ACC_W)) u_accum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (in_valid_i),
    .mul_hit_i  (mul_hit_w),
    .do_hit_i   (do_hit_w),
    .dont_hit_i (dont_hit_w),
    .op_a_i     (op_a_w),
    .op_b_i     (op_b_w),
    .end_i      (end_i),
    .sum_o      (sum_o),
    .done_o     (done_o),
    .en_o       (en_w)
  );
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker #(
  parameter int unsigned ACC_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic [7:0]       in_char_i,
  input logic             end_i,
  input logic [ACC_W-1:0] sum_o,
  input logic             done_o,
  input logic             en_i,
  input logic             do_hit_i,
  input logic             dont_hit_i
);
  logic close_w;
  assign close_w = in_valid_i && (in_char_i == 8'h29);

  // R4: no accepted close, no change to the sum
  a_r4_sum_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !close_w |-> ##2 $stable(sum_o));

  // R7
  a_r7_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##2 $stable(sum_o));

  // R6
  a_r6_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_w && !en_i) |-> ##2 $stable(sum_o));

  a_r6_do_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && do_hit_i) |=> en_i);

  a_r6_dont_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && dont_hit_i) |=> !en_i);

  // R8
  a_r8_done_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |-> ##2 done_o);

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
endmodule

bind mul_cmd_scanner mcs_checker #(.ACC_W(ACC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_char_i  (in_char_i),
  .end_i      (end_i),
  .sum_o      (sum_o),
  .done_o     (done_o),
  .en_i       (en_w),
  .do_hit_i   (do_hit_w),
  .dont_hit_i (dont_hit_w)
);

// File: tb/mul_cmd_scanner_tb.sv
module mul_cmd_scanner_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = 8'h00;
  logic        end_s = 1'b0;
  logic [31:0] sum;
  logic        done;
  int          n_chk = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  mul_cmd_scanner #(.OP_DIGITS(3), .ACC_W(32)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid),
    .in_char_i  (in_char),
    .end_i      (end_s),
    .sum_o      (sum),
    .done_o     (done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit isdig(byte c);
    return (c >= 8'h30) && (c <= 8'h39);
  endfunction

  // reference parser, walks back from each ')'
  function automatic logic [31:0] model(string s);
    logic [31:0] acc = 0;
    bit en = 1;
    for (int i = 0; i < s.len(); i++) begin
      int j, na, nb, va, vb, m;
      if (s[i] != 8'h29) continue;
      if (i >= 3 && s.substr(i-3, i) == "do()") en = 1;
      if (i >= 6 && s.substr(i-6, i) == "don't()") en = 0;
      j = i - 1; nb = 0; vb = 0; m = 1;
      while (j >= 0 && nb < 4 && isdig(s[j])) begin
        vb += (s[j] - 8'h30) * m; m *= 10; nb++; j--;
      end
      if (nb < 1 || nb > 3 || j < 0 || s[j] != 8'h2C) continue;
      j--; na = 0; va = 0; m = 1;
      while (j >= 0 && na < 4 && isdig(s[j])) begin
        va += (s[j] - 8'h30) * m; m *= 10; na++; j--;
      end
      if (na < 1 || na > 3 || j < 3) continue;
      if (s.substr(j-3, j) != "mul(") continue;
      if (en) acc = acc + 32'(va * vb);
    end
    return acc;
  endfunction

  function automatic string rand_stream(int n);
    string s = "";
    while (s.len() < n) begin
      case ($urandom_range(0, 9))
        0: s = {s, "mul("};
        1: s = {s, $sformatf("%0d", $urandom_range(0, 9))};
        2: s = {s, ","};
        3: s = {s, ")"};
        4: s = {s, "do()"};
        5: s = {s, "don't()"};
        6: s = {s, "x"};
        7: s = {s, "("};
        default: s = {s, $sformatf("mul(%0d,%0d)", $urandom_range(0, 1200), $urandom_range(0, 1200))};
      endcase
    end
    return s;
  endfunction

  task automatic reset_dut();
    rst_ni = 1'b0; in_valid = 1'b0; end_s = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // gaps: idle cycles carrying junk, including ')'
  task automatic run(input string s, input bit gaps, input bit end_late, input string req);
    logic [31:0] exp_fin, exp_pre;
    exp_fin = model(s);
    exp_pre = model(s.substr(0, s.len() - 2));
    reset_dut();
    for (int i = 0; i < s.len(); i++) begin
      if (gaps) begin
        int g = $urandom_range(0, 2);
        repeat (g) begin
          in_valid = 1'b0;
          in_char = ($urandom_range(0, 1) != 0) ? 8'h29 : 8'(s[$urandom_range(0, s.len() - 1)]);
          @(negedge clk);
        end
      end
      in_valid = 1'b1;
      in_char  = s[i];
      end_s    = !end_late && (i == s.len() - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_char = 8'h00; end_s = 1'b0;
    if (end_late) begin
      repeat (2) @(negedge clk);
      end_s = 1'b1;
      @(negedge clk);
      end_s = 1'b0;
      chk(sum == exp_fin, {req, " R4 sum before done"}, sum, exp_fin);
    end else begin
      chk(sum == exp_pre, {req, " R4 last product not yet visible"}, sum, exp_pre);
    end
    chk(done == 1'b0, {req, " R8 done one cycle after end"}, 32'(done), 0);
    @(negedge clk);
    chk(sum == exp_fin, {req, " sum final"}, sum, exp_fin);
    chk(done == 1'b1, {req, " R8 done high"}, 32'(done), 1);
    @(negedge clk);
    chk(done == 1'b1, {req, " R8 done held"}, 32'(done), 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(sum == 0, "R5 sum at reset", sum, 0);
    chk(done == 1'b0, "R5 done at reset", 32'(done), 0);

    run("mul(7,8)", 0, 0, "R1 basic");
    run("mul(3,4)x", 0, 1, "R5 adding on after reset");
    run("mul(1,2)mul(12,3)mul(123,4)mul(5,67)mul(89,10)mul(999,999)mul(4,567)mul(45,678)mul(321,12)",
        0, 0, "R1 R2 all length pairs");
    run("mul(007,010)mul(0,5)", 0, 0, "R2 leading zeros");
    run("mul(1234,5)mul(4,5 )mul[3,4)mul(1,)mul(,2)mul(12,3456)mul 2,3)mul(2;3)mux(2,3)",
        0, 0, "R3 malformed");
    run("mul(2,3)don't()mul(5,5)mul(9,9)do()mul(1,1)", 0, 0, "R6 toggle");
    run("don't()mul(9,9)do()don't()mul(2,2)", 0, 0, "R6 stays off");
    run("mul(5,6)mul(11,11)mul(3,3)", 1, 0, "R7 idle junk ignored");
    run("mul(5,6", 1, 1, "R7 junk close ignored");
    for (int r = 0; r < 10; r++) begin
      run(rand_stream(300), (r % 2) == 0, (r % 3) == 0, $sformatf("R1 R3 R6 random %0d", r));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule